// File: doc/BRIEF.md
# Interrupt Shadow and Halt Controller

This block decides when an in-order CPU core accepts an interrupt and when it sleeps. The pipeline reports each retired instruction with a two-bit class, its own PC and the PC that follows it. The block keeps the maskable-interrupt enable flag and the halted state. It also keeps a one-instruction delay window that opens when interrupts are switched on.

A maskable request is accepted only when the flag is set and the window is closed. A non-maskable request is accepted on its rising edge at any time. Each acceptance produces a single-cycle take strobe with its kind, the PC to restart at, and the enable value to save. The vector fetch and the handler are outside the block.

Because of the delay window, an enable instruction followed by a halt behaves as one atomic step. The core reaches its halted state before any maskable request can be taken, so a request that is already waiting wakes it on the next cycle instead of being lost. If a non-maskable request lands inside the window, the restart point moves back to the enable instruction and the saved flag is forced clear, so the pair re-executes together.

Top module: `irq_shadow_ctrl`

## Requirements
- R1: A retired instruction of class 1 (disable) clears `ie_flag`, and one of class 2 (enable) sets it; class 0 is any other instruction and leaves the flag alone.
- R2: A retired instruction of class 3 (halt) sets `halted`. While `halted` is high, retire strobes are ignored. An acceptance clears `halted`, and the restart PC is the PC that follows the halt.
- R3: While halted with `ie_flag` clear, a maskable request causes no take and the core stays halted.
- R4: After an enable retires with the flag previously clear, maskable requests stay blocked until one more instruction has retired.
- R5: When the instruction inside the window is a halt, the core halts first. A maskable request that is already pending is then taken on the next cycle, with the restart PC after the halt.
- R6: A non-maskable acceptance inside the window has these effects: the restart PC is the enable instruction's PC; the saved flag is 0; `ie_flag` is left clear; any retirement in that cycle is discarded.
- R7: An enable that retires while the flag is already set opens no window.
- R8: A non-maskable request is accepted on the rising edge of `nmi_req`, never while the line is merely held high. It wins over a maskable request pending in the same cycle.
- R9: `take_vld` and `take_nmi` are registered and appear on the edge that ends the accepting cycle. `take_pc` is the next PC of the last instruction that retired before that cycle. A retirement in the accepting cycle is discarded.
- R10: A maskable take clears `ie_flag` and reports `take_prev_ie`=1. A non-maskable take outside the window leaves `ie_flag` unchanged and reports it as `take_prev_ie`.
- R11: Synchronous reset leaves `ie_flag`, `halted` and `take_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_vld | input | 1 | One instruction retires this cycle |
| retire_cls | input | 2 | Class: 0 other, 1 disable, 2 enable, 3 halt |
| retire_pc | input | PC_W | PC of the retiring instruction |
| retire_next_pc | input | PC_W | PC that follows the retiring instruction |
| irq_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request |
| ie_flag | output | 1 | Maskable-interrupt enable flag |
| halted | output | 1 | Core is halted; retirement stops |
| take_vld | output | 1 | One-cycle interrupt-take strobe |
| take_nmi | output | 1 | Kind of take: 1 non-maskable, 0 maskable |
| take_pc | output | PC_W | Restart PC to save |
| take_prev_ie | output | 1 | Enable value to save |

## Verification
The bench builds the block with `PC_W` = 16 and `NMI_EDGE` = 1. With those values every retirement gets a distinct restart PC, so a take PC that points at the wrong instruction, or at the enable instead of after the halt, shows up as a plain miscompare. Edge detection of the non-maskable line is also in force, so holding `nmi_req` high while instructions keep retiring shows whether a second take is wrongly produced.

// File: rtl/irq_shadow_pkg.sv
package irq_shadow_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_DI    = 2'd1,
    CLS_EI    = 2'd2,
    CLS_HALT  = 2'd3
  } instr_cls_e;
endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter bit NMI_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic nmi_req,
  input  logic ie_q,
  input  logic shadow_q,
  output logic accept_nmi,
  output logic accept_irq
);
  logic nmi_pend;

  generate
    if (NMI_EDGE) begin : g_edge
      logic nmi_q;
      always_ff @(posedge clk) begin
        if (rst) nmi_q <= 1'b0;
        else     nmi_q <= nmi_req;
      end
      assign nmi_pend = nmi_req & ~nmi_q;
    end else begin : g_level
      assign nmi_pend = nmi_req;
    end
  endgenerate

  // Non-maskable wins; maskable needs the flag set and the window closed.
  assign accept_nmi = nmi_pend;
  assign accept_irq = irq_req & ie_q & ~shadow_q & ~nmi_pend;
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_shadow_pkg::*;
#(
  parameter int unsigned   PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ret_eff,
  input  instr_cls_e      cls,
  input  logic [PC_W-1:0] retire_pc,
  input  logic [PC_W-1:0] retire_next_pc,
  input  logic            accept_any,
  input  logic            accept_irq,
  input  logic            nmi_in_shadow,
  output logic            ie_q,
  output logic            shadow_q,
  output logic [PC_W-1:0] shadow_pc_q,
  output logic [PC_W-1:0] resume_pc_q
);
  logic opens_window;
  assign opens_window = ret_eff & (cls == CLS_EI) & ~ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 1'b0;
    end else if (accept_irq || nmi_in_shadow) begin
      ie_q <= 1'b0;
    end else if (ret_eff && cls == CLS_DI) begin
      ie_q <= 1'b0;
    end else if (ret_eff && cls == CLS_EI) begin
      ie_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             shadow_q <= 1'b0;
    else if (accept_any) shadow_q <= 1'b0;
    else if (ret_eff)    shadow_q <= opens_window;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_pc_q <= RESET_PC;
      resume_pc_q <= RESET_PC;
    end else begin
      if (opens_window) shadow_pc_q <= retire_pc;
      if (ret_eff)      resume_pc_q <= retire_next_pc;
    end
  end
endmodule

// File: rtl/irq_halt_unit.sv
module irq_halt_unit (
  input  logic clk,
  input  logic rst,
  input  logic ret_halt,
  input  logic accept_any,
  output logic halted_q
);
  always_ff @(posedge clk) begin
    if (rst)             halted_q <= 1'b0;
    else if (accept_any) halted_q <= 1'b0;
    else if (ret_halt)   halted_q <= 1'b1;
  end
endmodule

// File: rtl/irq_take_reg.sv
module irq_take_reg #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept_any,
  input  logic            accept_nmi,
  input  logic            nmi_in_shadow,
  input  logic            ie_q,
  input  logic [PC_W-1:0] shadow_pc_q,
  input  logic [PC_W-1:0] resume_pc_q,
  output logic            take_vld,
  output logic            take_nmi,
  output logic [PC_W-1:0] take_pc,
  output logic            take_prev_ie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      take_vld     <= 1'b0;
      take_nmi     <= 1'b0;
      take_pc      <= '0;
      take_prev_ie <= 1'b0;
    end else begin
      take_vld <= accept_any;
      take_nmi <= accept_nmi;
      if (accept_any) begin
        // Inside the window, restart at the enable with the flag saved clear.
        take_pc      <= nmi_in_shadow ? shadow_pc_q : resume_pc_q;
        take_prev_ie <= nmi_in_shadow ? 1'b0 : ie_q;
      end
    end
  end
endmodule

// File: rtl/irq_shadow_ctrl.sv
module irq_shadow_ctrl
  import irq_shadow_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter bit          NMI_EDGE = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            retire_vld,
  input  logic [1:0]      retire_cls,
  input  logic [PC_W-1:0] retire_pc,
  input  logic [PC_W-1:0] retire_next_pc,
  input  logic            irq_req,
  input  logic            nmi_req,
  output logic            ie_flag,
  output logic            halted,
  output logic            take_vld,
  output logic            take_nmi,
  output logic [PC_W-1:0] take_pc,
  output logic            take_prev_ie
);
  localparam logic [PC_W-1:0] RESET_PC = '0;

  instr_cls_e      cls;
  logic            accept_nmi, accept_irq, accept_any;
  logic            ret_eff, nmi_in_shadow;
  logic            ie_q, shadow_q, halted_q;
  logic [PC_W-1:0] shadow_pc_q, resume_pc_q;

  assign cls           = instr_cls_e'(retire_cls);
  assign accept_any    = accept_nmi | accept_irq;
  assign ret_eff       = retire_vld & ~halted_q & ~accept_any;
  assign nmi_in_shadow = accept_nmi & shadow_q;

  irq_req_gate #(.NMI_EDGE(NMI_EDGE)) gate_i (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .nmi_req    (nmi_req),
    .ie_q       (ie_q),
    .shadow_q   (shadow_q),
    .accept_nmi (accept_nmi),
    .accept_irq (accept_irq)
  );

  irq_flag_unit #(.PC_W(PC_W), .RESET_PC(RESET_PC)) flag_i (
    .clk            (clk),
    .rst            (rst),
    .ret_eff        (ret_eff),
    .cls            (cls),
    .retire_pc      (retire_pc),
    .retire_next_pc (retire_next_pc),
    .accept_any     (accept_any),
    .accept_irq     (accept_irq),
    .nmi_in_shadow  (nmi_in_shadow),
    .ie_q           (ie_q),
    .shadow_q       (shadow_q),
    .shadow_pc_q    (shadow_pc_q),
    .resume_pc_q    (resume_pc_q)
  );

  irq_halt_unit halt_i (
    .clk        (clk),
    .rst        (rst),
    .ret_halt   (ret_eff && cls == CLS_HALT),
    .accept_any (accept_any),
    .halted_q   (halted_q)
  );

  irq_take_reg #(.PC_W(PC_W)) take_i (
    .clk           (clk),
    .rst           (rst),
    .accept_any    (accept_any),
    .accept_nmi    (accept_nmi),
    .nmi_in_shadow (nmi_in_shadow),
    .ie_q          (ie_q),
    .shadow_pc_q   (shadow_pc_q),
    .resume_pc_q   (resume_pc_q),
    .take_vld      (take_vld),
    .take_nmi      (take_nmi),
    .take_pc       (take_pc),
    .take_prev_ie  (take_prev_ie)
  );

  assign ie_flag = ie_q;
  assign halted  = halted_q;
endmodule

// File: rtl/irq_shadow_chk.sv
module irq_shadow_chk #(
  parameter bit NMI_EDGE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic nmi_req,
  input logic ie_flag,
  input logic halted,
  input logic take_vld,
  input logic take_nmi,
  input logic take_prev_ie
);
  assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ie_flag && !halted && !take_vld));

  assert_take_wakes_R2: assert property (@(posedge clk) disable iff (rst)
    take_vld |-> !halted);

  assert_masked_halt_R3: assert property (@(posedge clk) disable iff (rst)
    (halted && !ie_flag) |=> !(take_vld && !take_nmi));

  assert_window_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ie_flag) |=> !(take_vld && !take_nmi));

  assert_irq_clears_ie_R10: assert property (@(posedge clk) disable iff (rst)
    (take_vld && !take_nmi) |-> (!ie_flag && take_prev_ie));

  generate
    if (NMI_EDGE) begin : g_edge_chk
      assert_nmi_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_req) |=> (take_vld && take_nmi));
    end
  endgenerate
endmodule

bind irq_shadow_ctrl irq_shadow_chk #(.NMI_EDGE(NMI_EDGE)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .nmi_req      (nmi_req),
  .ie_flag      (ie_flag),
  .halted       (halted),
  .take_vld     (take_vld),
  .take_nmi     (take_nmi),
  .take_prev_ie (take_prev_ie)
);

// File: tb/irq_shadow_ctrl_tb_top.sv
module irq_shadow_ctrl_tb_top;
  localparam int unsigned PC_W = 16;
  localparam int NV = 30;

  typedef struct packed {
    logic       rv;
    logic [1:0] cls;
    logic       irq;
    logic       nmi;
    logic       tv;
    logic       tn;
    logic [15:0] pc;
    logic       pie;
    logic       ie;
    logic       h;
  } vec_t;

  // rv cls irq nmi | tv tn pc pie ie h  (retire pc = 16*i, next = 16*i+4)
  localparam vec_t VEC [NV] = '{
    '{1'b1,2'd0,1'b1,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b0,1'b0}, // 0  R1 irq masked
    '{1'b1,2'd2,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 1  R1 enable
    '{1'b1,2'd0,1'b1,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 2  R4 window
    '{1'b0,2'd0,1'b1,1'b0, 1'b1,1'b0,16'd36, 1'b1,1'b0,1'b0}, // 3  R4 taken
    '{1'b1,2'd2,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 4
    '{1'b1,2'd3,1'b1,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b1}, // 5  R5 halt first
    '{1'b0,2'd0,1'b1,1'b0, 1'b1,1'b0,16'd84, 1'b1,1'b0,1'b0}, // 6  R5 wake
    '{1'b1,2'd2,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 7
    '{1'b1,2'd3,1'b0,1'b1, 1'b1,1'b1,16'd112,1'b0,1'b0,1'b0}, // 8  R6 nmi in window
    '{1'b1,2'd0,1'b0,1'b1, 1'b0,1'b0,16'd0,  1'b0,1'b0,1'b0}, // 9  R8 held nmi
    '{1'b1,2'd3,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b0,1'b1}, // 10 R2 halt
    '{1'b0,2'd0,1'b1,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b0,1'b1}, // 11 R3
    '{1'b1,2'd2,1'b1,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b0,1'b1}, // 12 R2 retire ignored
    '{1'b0,2'd0,1'b1,1'b1, 1'b1,1'b1,16'd164,1'b0,1'b0,1'b0}, // 13 R3 nmi wakes
    '{1'b1,2'd2,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 14
    '{1'b1,2'd2,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 15 R7
    '{1'b1,2'd0,1'b1,1'b0, 1'b1,1'b0,16'd244,1'b1,1'b0,1'b0}, // 16 R7 R9
    '{1'b1,2'd2,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 17
    '{1'b1,2'd1,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b0,1'b0}, // 18 R1 disable
    '{1'b0,2'd0,1'b1,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b0,1'b0}, // 19
    '{1'b1,2'd2,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 20
    '{1'b0,2'd0,1'b1,1'b1, 1'b1,1'b1,16'd320,1'b0,1'b0,1'b0}, // 21 R8 priority R6
    '{1'b1,2'd2,1'b0,1'b1, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 22
    '{1'b1,2'd0,1'b0,1'b1, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 23
    '{1'b0,2'd0,1'b1,1'b0, 1'b1,1'b0,16'd372,1'b1,1'b0,1'b0}, // 24 R10
    '{1'b0,2'd0,1'b0,1'b1, 1'b1,1'b1,16'd372,1'b0,1'b0,1'b0}, // 25
    '{1'b1,2'd2,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 26
    '{1'b1,2'd0,1'b0,1'b0, 1'b0,1'b0,16'd0,  1'b0,1'b1,1'b0}, // 27
    '{1'b0,2'd0,1'b0,1'b1, 1'b1,1'b1,16'd436,1'b1,1'b1,1'b0}, // 28 R10 nmi keeps ie
    '{1'b0,2'd0,1'b1,1'b0, 1'b1,1'b0,16'd436,1'b1,1'b0,1'b0}  // 29 R10
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            retire_vld = 1'b0;
  logic [1:0]      retire_cls = 2'd0;
  logic [PC_W-1:0] retire_pc = '0;
  logic [PC_W-1:0] retire_next_pc = '0;
  logic            irq_req = 1'b0;
  logic            nmi_req = 1'b0;
  logic            ie_flag, halted, take_vld, take_nmi, take_prev_ie;
  logic [PC_W-1:0] take_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_shadow_ctrl #(.PC_W(PC_W), .NMI_EDGE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .retire_vld(retire_vld), .retire_cls(retire_cls),
    .retire_pc(retire_pc), .retire_next_pc(retire_next_pc),
    .irq_req(irq_req), .nmi_req(nmi_req), .ie_flag(ie_flag), .halted(halted),
    .take_vld(take_vld), .take_nmi(take_nmi), .take_pc(take_pc),
    .take_prev_ie(take_prev_ie)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input vec_t e);
    check(req, "take_vld", int'(take_vld), int'(e.tv));
    check(req, "ie_flag",  int'(ie_flag),  int'(e.ie));
    check(req, "halted",   int'(halted),   int'(e.h));
    if (e.tv) begin
      check(req, "take_nmi",     int'(take_nmi),     int'(e.tn));
      check(req, "take_pc",      int'(take_pc),      int'(e.pc));
      check(req, "take_prev_ie", int'(take_prev_ie), int'(e.pie));
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R11: state during and after reset
    check("R11", "ie_flag", int'(ie_flag), 0);
    check("R11", "halted", int'(halted), 0);
    check("R11", "take_vld", int'(take_vld), 0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      retire_vld     = VEC[i].rv;
      retire_cls     = VEC[i].cls;
      retire_pc      = PC_W'(16 * i);
      retire_next_pc = PC_W'(16 * i + 4);
      irq_req        = VEC[i].irq;
      nmi_req        = VEC[i].nmi;
      @(negedge clk);
      check_state($sformatf("R1-vec%0d", i), VEC[i]);
    end
    // R11: reset from an enabled, halted state
    retire_vld = 1'b1; retire_cls = 2'd2; irq_req = 1'b0; nmi_req = 1'b0;
    @(negedge clk);
    retire_cls = 2'd3;
    @(negedge clk);
    retire_vld = 1'b0;
    check("R2", "halted before reset", int'(halted), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11", "ie_flag after reset", int'(ie_flag), 0);
    check("R11", "halted after reset", int'(halted), 0);
    check("R11", "take_vld after reset", int'(take_vld), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule